// File: doc/BRIEF.md
# MDIO Management Master with Command/Data Registers

This block lets a processor reach the management registers of external Ethernet PHYs over a two-wire MDIO bus. Software starts a Clause 22 transaction with one 32-bit store to a command register. That single word holds the write data, the operation, the PHY address and the register address, and its busy bit starts the transfer. The block then runs MDC and shifts out the 64-bit frame. On a write it drives MDIO for the whole frame. On a read it releases MDIO after the address field and captures the PHY's answer.

Software learns that a transaction has finished only from the busy bit: it writes the command word with busy set and polls until the bit reads zero again. The 16-bit result of a read is placed in a separate data register. Software may overwrite that register at any time, for example to reset it to all ones once the result has been consumed. The stored value then reads back unchanged until the next read completes. MDC comes from the system clock through a parameterised divider whose default keeps it at 2.5 MHz from a 100 MHz clock. MDC rests low whenever no frame is in flight.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: The command register decodes at byte offset 0xCC and the read-data register at 0xD0. The read-data register returns its value in bits 15:0 with bits 31:16 zero. A read of any other offset returns zero.
- R2: While reset is asserted and after it is released, the busy bit reads 0, the read-data register reads 0x0000FFFF, MDC is low and the MDIO output enable is low.
- R3: The command word is laid out as follows: bits 31:16 hold the write data, bit 15 is busy, bit 11 requests a read, bit 10 requests a write, bits 9:5 hold the PHY address and bits 4:0 hold the register address. A store to the command register with bit 15 set and exactly one of bits 11 and 10 set starts a frame. The busy bit then reads 1 from the next cycle until the frame ends.
- R4: Each frame has exactly 64 MDC rising edges, and every field is sent most significant bit first. The order is 32 ones, start bits 0 then 1, the opcode (1,0 for a read; 0,1 for a write), the PHY address, the register address, a two-bit turnaround and 16 data bits.
- R5: On a write, the output enable is high at all 64 rising edges, the turnaround is driven as 1 then 0, and the data field carries command bits 31:16.
- R6: On a read, the output enable is high for the first 46 bits and low from the turnaround to the end of the frame. MDIO is sampled on the 16 rising edges of the data field, and the captured value appears in read-data bits 15:0 when busy clears.
- R7: MDC has a period of exactly 2×DIV_HALF system clock cycles during a frame and is low whenever busy is 0.
- R8: A command store with bit 15 set and both or neither of bits 11 and 10 set raises busy for exactly one cycle and sends no frame.
- R9: Stores to the command register while busy is 1 are ignored. The frame in flight and the command readback are unchanged.
- R10: A store to the read-data register saves its bits 15:0. That value reads back unchanged, including across write transactions, until the next read completes.
- R11: A command store with bit 15 clear starts nothing, and busy stays 0.
- R12: Reading the command register returns the last accepted command word with the current busy state in bit 15 and bits 14:12 as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, combinational during a load |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable, 1 = drive |

## Verification
The bench runs write and read frames over every PHY address and every register address. A behavioural PHY on the pins answers reads with computed data and records each bit at MDC rising edges. Each frame is compared with one built arithmetically from the command word. A shift that is off by one or an opcode that is swapped would show up as a miscompare in the recorded bits, and a turnaround that is released late would show up in the output-enable pattern. Read capture is checked against the PHY's value, so sampling on the wrong MDC edge returns a shifted result. The remaining tests target the edge cases. Malformed and unarmed command words must leave MDC silent and let busy clear on time. A second command issued during a frame must not disturb that frame. A value stored in the data register must survive a write transaction but be replaced by the next read.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  // Command word bit positions (software-visible)
  localparam int WD_LSB   = 16;
  localparam int BUSY_BIT = 15;
  localparam int RD_BIT   = 11;
  localparam int WR_BIT   = 10;
  localparam int PHY_LSB  = 5;

  // Frame geometry
  localparam int          FRAME_LEN = 64;
  localparam int          IDX_W     = $clog2(FRAME_LEN);
  localparam logic [5:0]  TA_IDX    = 6'd46;
  localparam logic [5:0]  DATA_IDX  = 6'd48;
  localparam logic [5:0]  LAST_IDX  = 6'd63;

  typedef struct packed {
    logic [15:0] wdata;
    logic        rd;
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
  } mgmt_cmd_t;

  // Full 64-bit serial image of one management frame, index 0 in bit 63.
  function automatic logic [FRAME_LEN-1:0] frame_bits(input mgmt_cmd_t c);
    logic [1:0]  op;
    logic [15:0] d;
    op = c.rd ? 2'b10 : 2'b01;
    d  = c.rd ? 16'h0000 : c.wdata;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, 2'b10, d};
  endfunction

endpackage

// File: rtl/phy_mgmt_clkdiv.sv
module phy_mgmt_clkdiv #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (DIV_HALF <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] TOP = CW'(DIV_HALF - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign tick   = run && (cnt_q == TOP);
      assign cnt_en = run || (cnt_q != '0);

      always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'hCC,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seq_done,
  input  logic              rd_done,
  input  logic [15:0]       rd_value,
  output logic              start,
  output mgmt_cmd_t         launch_cmd,
  output mgmt_cmd_t         held_cmd,
  output logic              busy,
  output logic              cmd_hit,
  output logic              data_hit,
  output logic [15:0]       data_q
);

  logic      busy_q, busy_d;
  logic      noop_q, noop_d;
  mgmt_cmd_t held_q;
  logic [15:0] dat_q, dat_d;
  logic      dat_en;
  logic      accept, op_ok;

  assign cmd_hit  = bus_sel && bus_wr && (bus_addr == CMD_OFS);
  assign data_hit = bus_sel && bus_wr && (bus_addr == DATA_OFS);

  always_comb begin
    launch_cmd.wdata = bus_wdata[31:WD_LSB];
    launch_cmd.rd    = bus_wdata[RD_BIT];
    launch_cmd.wr    = bus_wdata[WR_BIT];
    launch_cmd.phy   = bus_wdata[PHY_LSB+4:PHY_LSB];
    launch_cmd.regad = bus_wdata[4:0];
  end

  assign accept = cmd_hit && !busy_q && bus_wdata[BUSY_BIT];
  assign op_ok  = launch_cmd.rd ^ launch_cmd.wr;
  assign start  = accept && op_ok;

  // Next-state
  always_comb begin
    busy_d = busy_q;
    noop_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      noop_d = !op_ok;
    end else if (noop_q || seq_done) begin
      busy_d = 1'b0;
    end
  end

  always_comb begin
    dat_en = rd_done || data_hit;
    dat_d  = rd_done ? rd_value : bus_wdata[15:0];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      noop_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      noop_q <= noop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (accept) held_q <= launch_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= 16'hFFFF;
    else if (dat_en) dat_q <= dat_d;
  end

  // Load path
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == CMD_OFS)
        bus_rdata = {held_q.wdata, busy_q, 3'b000, held_q.rd, held_q.wr,
                     held_q.phy, held_q.regad};
      else if (bus_addr == DATA_OFS)
        bus_rdata = {16'h0000, dat_q};
    end
  end

  assign busy     = busy_q;
  assign held_cmd = held_q;
  assign data_q   = dat_q;

endmodule

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
  import phy_mgmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  mgmt_cmd_t launch_cmd,
  input  logic      tick,
  input  logic      mdio_i,
  output logic      mdc,
  output logic      mdio_o,
  output logic      mdio_oe,
  output logic      active,
  output logic      done,
  output logic      rd_done,
  output logic [15:0] rd_value
);

  logic                 act_q, act_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 mdc_q, mdc_d;
  logic                 rdm_q, rdm_d;
  logic [15:0]          cap_q, cap_d;
  logic                 step_en;

  assign step_en = start || (act_q && tick);

  // Next-state
  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    mdc_d = mdc_q;
    rdm_d = rdm_q;
    cap_d = cap_q;
    done  = 1'b0;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      sh_d  = frame_bits(launch_cmd);
      mdc_d = 1'b0;
      rdm_d = launch_cmd.rd;
    end else if (act_q && tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (rdm_q && (idx_q >= DATA_IDX))
          cap_d = {cap_q[14:0], mdio_i};
      end else begin
        mdc_d = 1'b0;
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == LAST_IDX) begin
          act_d = 1'b0;
          done  = 1'b1;
        end
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '1;
      mdc_q <= 1'b0;
      rdm_q <= 1'b0;
      cap_q <= 16'hFFFF;
    end else if (step_en) begin
      act_q <= act_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      mdc_q <= mdc_d;
      rdm_q <= rdm_d;
      cap_q <= cap_d;
    end
  end

  assign mdc      = mdc_q;
  assign mdio_o   = sh_q[FRAME_LEN-1];
  assign mdio_oe  = act_q && !(rdm_q && (idx_q >= TA_IDX));
  assign active   = act_q;
  assign rd_done  = done && rdm_q;
  assign rd_value = cap_q;

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'hCC,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hD0,
  parameter int                DIV_HALF = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);

  logic        start, busy, cmd_hit, data_hit;
  logic        seq_active, seq_done, rd_done, tick;
  logic [15:0] rd_value, data_q;
  mgmt_cmd_t   launch_cmd, held_cmd;

  phy_mgmt_regs #(
    .ADDR_W  (ADDR_W),
    .CMD_OFS (CMD_OFS),
    .DATA_OFS(DATA_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .seq_done  (seq_done),
    .rd_done   (rd_done),
    .rd_value  (rd_value),
    .start     (start),
    .launch_cmd(launch_cmd),
    .held_cmd  (held_cmd),
    .busy      (busy),
    .cmd_hit   (cmd_hit),
    .data_hit  (data_hit),
    .data_q    (data_q)
  );

  phy_mgmt_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (seq_active),
    .tick (tick)
  );

  phy_mgmt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .launch_cmd(launch_cmd),
    .tick      (tick),
    .mdio_i    (mdio_i),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .active    (seq_active),
    .done      (seq_done),
    .rd_done   (rd_done),
    .rd_value  (rd_value)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
  import phy_mgmt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        seq_active,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        cmd_hit,
  input logic        data_hit,
  input logic        rd_done,
  input logic [15:0] data_q,
  input mgmt_cmd_t   held_cmd
);

  // R7
  mdc_rest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R5
  oe_released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |-> !mdio_oe);

  // R3
  frame_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> busy);

  // R8
  noop_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_active) |=> !busy);

  // R9
  busy_store_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_hit) |=> $stable(held_cmd));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_hit && !rd_done) |=> $stable(data_q));

endmodule

bind phy_mgmt_ctrl phy_mgmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .seq_active(seq_active),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe),
  .cmd_hit   (cmd_hit),
  .data_hit  (data_hit),
  .rd_done   (rd_done),
  .data_q    (data_q),
  .held_cmd  (held_cmd)
);

// File: tb/sim_phy_mgmt_ctrl.sv
module sim_phy_mgmt_ctrl;

  localparam int DIVH = 2;
  localparam logic [7:0] CMD  = 8'hCC;
  localparam logic [7:0] DATA = 8'hD0;
  localparam logic [63:0] RD_OE_MASK = 64'hFFFF_FFFF_FFFC_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  phy_mgmt_ctrl #(.DIV_HALF(DIVH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int vectors = 0;
  int miscompares = 0;

  // PHY model / pin monitor
  logic        mon_clr = 1'b0;
  logic [15:0] resp = 16'h0000;
  logic        prev_mdc = 1'b0;
  int          rises = 0;
  int          cyc = 0;
  int          last_rise = 0;
  logic        per_bad = 1'b0;
  logic [63:0] cap_o = '0, cap_oe = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      rises = 0; cap_o = '0; cap_oe = '0; per_bad = 1'b0; mdio_i = 1'b1;
    end else begin
      if (mdc && !prev_mdc) begin
        if (rises > 0 && (cyc - last_rise) != 2*DIVH) per_bad = 1'b1;
        last_rise = cyc;
        cap_o  = {cap_o[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        rises  = rises + 1;
      end
      if (!mdc && prev_mdc)
        mdio_i = (rises >= 48 && rises <= 63) ? resp[63-rises] : 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic mon_reset();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] w;
    for (int n = 0; n < 5000; n++) begin
      bus_read(CMD, w);
      if (!w[15]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
  endfunction

  task automatic run_txn(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rsp);
    logic [31:0] w, word;
    logic [63:0] ef;
    resp = rsp;
    mon_reset();
    word = {wd, 1'b1, 3'b000, rd, !rd, phy, ra};
    bus_write(CMD, word);
    bus_read(CMD, w);
    check("R3 busy after launch", 64'(w[15]), 64'd1);
    wait_idle();
    @(negedge clk);
    check("R4 rising edge count", 64'(rises), 64'd64);
    ef = exp_frame(rd, phy, ra, wd);
    if (rd) begin
      check("R4 R6 read frame bits", cap_o & RD_OE_MASK, ef & RD_OE_MASK);
      check("R6 read output enable", cap_oe, RD_OE_MASK);
    end else begin
      check("R4 R5 write frame bits", cap_o, ef);
      check("R5 write output enable", cap_oe, '1);
    end
    check("R7 mdc period and idle", {62'd0, per_bad, mdc}, 64'd0);
    bus_read(CMD, w);
    check("R12 command readback", 64'(w), 64'(word & ~32'h0000_8000));
    if (rd) begin
      bus_read(DATA, w);
      check("R6 read result", 64'(w), 64'(rsp));
    end
  endtask

  task automatic bad_cmd(input logic [31:0] word, input logic expect_pulse, input string tag);
    logic [31:0] w;
    mon_reset();
    bus_write(CMD, word);
    bus_read(CMD, w);
    check(tag, 64'(w[15]), 64'(expect_pulse));
    @(negedge clk);
    bus_read(CMD, w);
    check(tag, 64'(w[15]), 64'd0);
    repeat (20) @(negedge clk);
    check(tag, {62'd0, mdio_oe, mdc}, 64'd0);
    check(tag, 64'(rises), 64'd0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares + 1);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    check("R2 idle pins in reset", {62'd0, mdio_oe, mdc}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(CMD, w);
    check("R2 busy after reset", 64'(w[15]), 64'd0);
    bus_read(DATA, w);
    check("R2 R1 data reg after reset", 64'(w), 64'h0000_FFFF);
    check("R2 idle pins", {62'd0, mdio_oe, mdc}, 64'd0);
    bus_read(8'h00, w);
    check("R1 unmapped offset 0x00", 64'(w), 64'd0);
    bus_read(8'hC8, w);
    check("R1 unmapped offset 0xC8", 64'(w), 64'd0);

    // PHY-address sweep, write and read
    for (int p = 0; p < 32; p++) begin
      run_txn(1'b0, 5'(p), 5'(p) ^ 5'h15, 16'h3C5A ^ 16'(p * 2323), 16'h0000);
      run_txn(1'b1, 5'(p), 5'(31 - p), 16'h0000, 16'hA5C3 ^ 16'(p * 1057));
    end
    // Register-address sweep, reads with nonzero data field
    for (int r = 0; r < 32; r++)
      run_txn(1'b1, 5'(r) ^ 5'h01, 5'(r), 16'hFFFF, 16'h5AA5 ^ 16'(r * 4099));

    // R10: software-written data persists over a write, replaced by a read
    bus_write(DATA, 32'hABCD_1234);
    bus_read(DATA, w);
    check("R10 data store readback", 64'(w), 64'h0000_1234);
    run_txn(1'b0, 5'd9, 5'd4, 16'h8001, 16'h0000);
    bus_read(DATA, w);
    check("R10 data kept over write frame", 64'(w), 64'h0000_1234);
    run_txn(1'b1, 5'd9, 5'd4, 16'h0000, 16'hBEEF);
    bus_write(DATA, 32'h0000_FFFF);
    bus_read(DATA, w);
    check("R10 data store all ones", 64'(w), 64'h0000_FFFF);

    // R8: malformed operation fields
    bad_cmd(32'h1234_8C21, 1'b1, "R8 both op bits");
    bad_cmd(32'h1234_8021, 1'b1, "R8 neither op bit");
    // R11: busy bit clear
    bad_cmd(32'h1234_0821, 1'b0, "R11 unarmed command");

    // R9: second command during a frame
    begin
      logic [63:0] ef;
      resp = 16'h0F0F;
      mon_reset();
      bus_write(CMD, {16'h0000, 1'b1, 3'b000, 1'b1, 1'b0, 5'd3, 5'd7});
      repeat (10) @(negedge clk);
      bus_write(CMD, {16'h5555, 1'b1, 3'b000, 1'b0, 1'b1, 5'd12, 5'd20});
      bus_read(CMD, w);
      check("R9 readback phy unchanged", 64'(w[9:5]), 64'd3);
      wait_idle();
      @(negedge clk);
      ef = exp_frame(1'b1, 5'd3, 5'd7, 16'h0000);
      check("R9 frame unchanged", cap_o & RD_OE_MASK, ef & RD_OE_MASK);
      check("R9 edge count", 64'(rises), 64'd64);
      bus_read(DATA, w);
      check("R9 R6 first command result", 64'(w), 64'h0000_0F0F);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule